// File: doc/BRIEF.md
# Nonvolatile Byte Array Write and Erase Controller

This block is the device-side write path of an electrically erasable byte memory. A host strobes the latch-enable input high for a number of clock cycles while presenting an address, a data byte and two high-voltage indication flags. The controller measures the strobe, classifies it, and then applies one of three effects to the array. A programming strobe can only clear bits in the addressed byte. A chip erase sets every byte to all ones. A strobe without the programming-voltage flag, or with latch-enable held low, changes nothing. This lets several devices share address and data lines while only the targeted one acts.

Chip erase has two entry paths. The direct path needs a static pin pattern: both high-voltage flags set, address bit 10 high, and address bits 8 and 11 low. The command path needs two strobes in order, 0xAA written to 0x5555 and then 0x10 written to 0x2AAA. Each of these strobes must have a width inside its own cycle window. Once a program or an erase has taken effect, the controller latches into the matching verify mode. The array stays readable there but cannot be altered. Only reset, which stands for power-down, returns it to normal read. Reset does not touch the array contents.

Mode state machine: `MODE_READ` goes to `MODE_PGM_VFY` on a program and to `MODE_ERS_VFY` on an erase. Both verify states hold until reset. Unlock state machine: `SEQ_IDLE` goes to `SEQ_ARMED` when the first command arrives with a width in window. `SEQ_ARMED` goes back to `SEQ_IDLE` on any further qualifying strobe. That strobe fires the erase if it is the second command and its width is in window.

Top module: `nvm_write_ctrl`

## Requirements
- R1: After reset the mode output is 2'b00 (normal read). The encodings are 2'b01 for program-verify and 2'b10 for erase-verify, and 2'b11 never appears.
- R2: `rd_data` shows the byte at `rd_addr` one clock after `rd_addr` is applied, in every mode. Array contents survive reset.
- R3: A strobe with the programming flag set, which is neither the direct-erase pattern nor an unlock command, replaces byte `addr[ARR_AW-1:0]` with old AND `din`. All other bytes are unchanged and the mode becomes program-verify. Address, data and flags are sampled at the first clock edge that sees `ale` high. The width is the count of edges that see it high. The effect appears at the second edge after the first edge that sees `ale` low.
- R4: A strobe with both flags set, `addr[10]`=1 and `addr[8]`=`addr[11]`=0 sets every byte to 0xFF and enters erase-verify, whatever its width.
- R5: A strobe writing 0xAA to 0x5555 with width in [C1_MIN, C1_MAX], followed by a strobe writing 0x10 to 0x2AAA with width in [C2_MIN, C2_MAX], sets every byte to 0xFF and enters erase-verify. Both strobes must carry the programming flag. The window bounds themselves are accepted.
- R6: If the first command's width is outside its window, the array is not changed and the sequence is not armed. If the second command's width is outside its window, the array is not changed, the mode stays normal read and the sequence returns to idle.
- R7: In the armed state, a strobe with the wrong address or data is consumed without changing the array, and it disarms the sequence. A correct sequence afterwards still erases. Outside the armed state, a 0x2AAA/0x10 strobe is an ordinary program.
- R8: In either verify mode, no strobe changes the array or the mode until reset.
- R9: Strobes without the programming flag, and any period with `ale` held low, leave the array and the mode unchanged.
- R10: The direct-erase pattern takes priority over programming and over an armed sequence. Raising the A9 flag without the full pattern still programs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-down) |
| ale | input | 1 | Latch-enable strobe, active high |
| hv_prog | input | 1 | Programming voltage present |
| hv_a9 | input | 1 | High voltage on address pin 9 |
| addr | input | 16 | Command/target address |
| din | input | 8 | Data byte |
| rd_addr | input | ARR_AW | Read address |
| rd_data | output | 8 | Registered read data |
| mode | output | 2 | 00 read, 01 program-verify, 10 erase-verify |

## Verification
The bench builds the block with a 32-byte array, a 6-bit width counter, a first-command window of 4 to 8 cycles and a second-command window of 16 to 24 cycles. These small windows let every boundary be driven in a few cycles: each bound itself, one cycle below the low bound and one cycle above the high bound. A random mix of programs, both erase paths, aborted sequences and unpowered strobes then runs against a bench model. The small array can be read back in full after every operation, so stray writes to other bytes are caught.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] UNL1_ADDR = 16'h5555;
    localparam logic [ADDR_W-1:0] UNL2_ADDR = 16'h2AAA;
    localparam logic [DATA_W-1:0] UNL1_DATA = 8'hAA;
    localparam logic [DATA_W-1:0] UNL2_DATA = 8'h10;

    typedef enum logic [1:0] {
        MODE_READ    = 2'b00,
        MODE_PGM_VFY = 2'b01,
        MODE_ERS_VFY = 2'b10
    } mode_e;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              hv;
        logic              a9hv;
    } strobe_t;
endpackage

// File: rtl/nvm_strobe_meter.sv
module nvm_strobe_meter
    import nvm_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic              hv,
    input  logic              a9hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              done,
    output logic [CNT_W-1:0]  width,
    output strobe_t           info
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             ale_q;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_q <= 1'b0;
            cnt   <= '0;
            done  <= 1'b0;
            width <= '0;
            info  <= '0;
        end else begin
            ale_q <= ale;
            done  <= 1'b0;
            if (ale && !ale_q) begin
                cnt  <= CNT_ONE;
                info <= '{addr: addr, data: data, hv: hv, a9hv: a9hv};
            end else if (ale && cnt != '1) begin
                cnt <= cnt + CNT_ONE;
            end
            if (!ale && ale_q) begin
                done  <= 1'b1;
                width <= cnt;
            end
        end
    end

    // R3: a completed strobe is reported for exactly one cycle
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3: a reported strobe was seen high at least once
    a_r3_width_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (width != '0));
    // R9: no completion while latch enable stays low
    a_r9_quiet_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && !$past(ale)) |=> !done);
endmodule

// File: rtl/nvm_unlock_seq.sv
module nvm_unlock_seq
    import nvm_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int C1_MIN = 4,
    parameter int C1_MAX = 8,
    parameter int C2_MIN = 16,
    parameter int C2_MAX = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic [CNT_W-1:0]  width,
    output logic              consume,
    output logic              erase_go
);
    localparam logic [CNT_W-1:0] W1_LO = CNT_W'(C1_MIN);
    localparam logic [CNT_W-1:0] W1_HI = CNT_W'(C1_MAX);
    localparam logic [CNT_W-1:0] W2_LO = CNT_W'(C2_MIN);
    localparam logic [CNT_W-1:0] W2_HI = CNT_W'(C2_MAX);

    seq_e st_q, st_n;
    logic match1, match2, in1, in2;

    assign match1 = (addr == UNL1_ADDR) && (data == UNL1_DATA);
    assign match2 = (addr == UNL2_ADDR) && (data == UNL2_DATA);
    assign in1    = (width >= W1_LO) && (width <= W1_HI);
    assign in2    = (width >= W2_LO) && (width <= W2_HI);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SEQ_IDLE;
        else        st_q <= st_n;
    end

    always_comb begin
        st_n     = st_q;
        consume  = 1'b0;
        erase_go = 1'b0;
        unique case (st_q)
            SEQ_IDLE: begin
                if (step && match1) begin
                    consume = 1'b1;
                    if (in1) st_n = SEQ_ARMED;
                end
            end
            SEQ_ARMED: begin
                if (step) begin
                    consume = 1'b1;
                    st_n    = SEQ_IDLE;
                    if (match2 && in2) erase_go = 1'b1;
                end
            end
            default: st_n = SEQ_IDLE;
        endcase
    end

    // R6: arming only follows a first command inside its window
    a_r6_arm_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == SEQ_ARMED) |-> ($past(step) && $past(width) >= W1_LO && $past(width) <= W1_HI));
    // R7: any qualifying strobe while armed disarms
    a_r7_armed_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SEQ_ARMED && step) |=> (st_q == SEQ_IDLE));
    // R5: the erase trigger is never raised without a strobe
    a_r5_go_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> step);
endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array
    import nvm_pkg::*;
#(
    parameter int ARR_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ARR_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ers_en,
    input  logic [ARR_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ARR_AW;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              all_ff;

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (ers_en)
                mem[i] <= '1;
            else if (wr_en && wr_addr == ARR_AW'(i))
                mem[i] <= mem[i] & wr_data;
        end
        rd_data <= mem[rd_addr];
    end

    always_comb begin
        all_ff = 1'b1;
        for (int i = 0; i < DEPTH; i++)
            if (mem[i] != '1) all_ff = 1'b0;
    end

    // R3: programming never turns a zero bit into a one
    a_r3_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((mem[$past(wr_addr)] & ~$past(mem[wr_addr])) == '0));
    // R4: an erase leaves every byte at all ones
    a_r4_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        ers_en |=> all_ff);
    // R4: erase and program are never requested together
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && ers_en));
endmodule

// File: rtl/nvm_write_ctrl.sv
module nvm_write_ctrl
    import nvm_pkg::*;
#(
    parameter int ARR_AW = 5,
    parameter int CNT_W  = 6,
    parameter int C1_MIN = 4,
    parameter int C1_MAX = 8,
    parameter int C2_MIN = 16,
    parameter int C2_MAX = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic              hv_prog,
    input  logic              hv_a9,
    input  logic [15:0]       addr,
    input  logic [7:0]        din,
    input  logic [ARR_AW-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [1:0]        mode
);
    logic             done;
    logic [CNT_W-1:0] width;
    strobe_t          info;
    logic             direct, live, step, consume, erase_go, wr_en, ers_en;
    mode_e            mode_q, mode_n;

    nvm_strobe_meter #(.CNT_W(CNT_W)) u_meter (
        .clk(clk), .rst_n(rst_n), .ale(ale), .hv(hv_prog), .a9hv(hv_a9),
        .addr(addr), .data(din), .done(done), .width(width), .info(info)
    );

    nvm_unlock_seq #(
        .CNT_W(CNT_W), .C1_MIN(C1_MIN), .C1_MAX(C1_MAX),
        .C2_MIN(C2_MIN), .C2_MAX(C2_MAX)
    ) u_unlock (
        .clk(clk), .rst_n(rst_n), .step(step), .addr(info.addr),
        .data(info.data), .width(width), .consume(consume), .erase_go(erase_go)
    );

    nvm_cell_array #(.ARR_AW(ARR_AW)) u_array (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(info.addr[ARR_AW-1:0]),
        .wr_data(info.data), .ers_en(ers_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign direct = info.hv && info.a9hv && info.addr[10] && !info.addr[8] && !info.addr[11];

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_READ;
        else        mode_q <= mode_n;
    end

    always_comb begin
        live   = done && info.hv && (mode_q == MODE_READ);
        step   = live && !direct;
        wr_en  = step && !consume;
        ers_en = (live && direct) || erase_go;
        mode_n = mode_q;
        unique case (mode_q)
            MODE_READ: begin
                if (ers_en)     mode_n = MODE_ERS_VFY;
                else if (wr_en) mode_n = MODE_PGM_VFY;
            end
            MODE_PGM_VFY: mode_n = MODE_PGM_VFY;
            MODE_ERS_VFY: mode_n = MODE_ERS_VFY;
            default:      mode_n = MODE_READ;
        endcase
    end

    assign mode = mode_q;

    // R1: only the three defined encodings appear
    a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11);
    // R8: a verify mode holds until reset
    a_r8_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_READ) |=> (mode_q == $past(mode_q)));
    // R8: no array change is requested while locked
    a_r8_no_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_READ) |-> (!wr_en && !ers_en));
    // R9: the mode moves only on a completed strobe
    a_r9_still_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(mode_q));
    // R4: any erase lands in erase-verify
    a_r4_erase_locks: assert property (@(posedge clk) disable iff (!rst_n)
        ers_en |=> (mode_q == MODE_ERS_VFY));
endmodule

// File: tb/test_nvm_write_ctrl.sv
module test_nvm_write_ctrl;
    localparam int ARR_AW = 5;
    localparam int DEPTH  = 1 << ARR_AW;
    localparam int C1_MIN = 4, C1_MAX = 8, C2_MIN = 16, C2_MAX = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ale = 1'b0, hv_prog = 1'b0, hv_a9 = 1'b0;
    logic [15:0]       addr = '0;
    logic [7:0]        din = '0;
    logic [ARR_AW-1:0] rd_addr = '0;
    logic [7:0]        rd_data;
    logic [1:0]        mode;

    int          n_chk = 0, n_fail = 0;
    bit          finished = 1'b0;
    logic [7:0]  ref_mem [DEPTH];
    logic [1:0]  ref_mode = 2'b00;
    bit          ref_armed = 1'b0;

    always #2.5 clk = ~clk;

    nvm_write_ctrl #(
        .ARR_AW(ARR_AW), .CNT_W(6), .C1_MIN(C1_MIN), .C1_MAX(C1_MAX),
        .C2_MIN(C2_MIN), .C2_MAX(C2_MAX)
    ) i_nvm_write_ctrl (
        .clk(clk), .rst_n(rst_n), .ale(ale), .hv_prog(hv_prog), .hv_a9(hv_a9),
        .addr(addr), .din(din), .rd_addr(rd_addr), .rd_data(rd_data), .mode(mode)
    );

    function automatic bit in_win(int w, int lo, int hi);
        return (w >= lo) && (w <= hi);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ref_mode  = 2'b00;
        ref_armed = 1'b0;
        @(negedge clk);
    endtask

    // bench model of one strobe, written from the requirements
    task automatic model(bit hv, bit a9, logic [15:0] a, logic [7:0] d, int w);
        if (ref_mode != 2'b00 || !hv) return;
        if (a9 && a[10] && !a[8] && !a[11]) begin
            foreach (ref_mem[i]) ref_mem[i] = 8'hFF;
            ref_mode = 2'b10;
        end else if (ref_armed) begin
            ref_armed = 1'b0;
            if (a == 16'h2AAA && d == 8'h10 && in_win(w, C2_MIN, C2_MAX)) begin
                foreach (ref_mem[i]) ref_mem[i] = 8'hFF;
                ref_mode = 2'b10;
            end
        end else if (a == 16'h5555 && d == 8'hAA) begin
            ref_armed = in_win(w, C1_MIN, C1_MAX);
        end else begin
            ref_mem[a[ARR_AW-1:0]] = ref_mem[a[ARR_AW-1:0]] & d;
            ref_mode = 2'b01;
        end
    endtask

    task automatic strobe(bit hv, bit a9, logic [15:0] a, logic [7:0] d, int w);
        @(negedge clk);
        hv_prog = hv; hv_a9 = a9; addr = a; din = d; ale = 1'b1;
        repeat (w) @(negedge clk);
        ale = 1'b0;
        repeat (4) @(negedge clk);
        model(hv, a9, a, d, w);
    endtask

    task automatic check_mode(string tag);
        check(mode == ref_mode, tag, mode, ref_mode);
    endtask

    task automatic check_array(string tag);
        bit ok = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            rd_addr = ARR_AW'(i);
            @(negedge clk);
            if (rd_data !== ref_mem[i]) begin
                ok = 1'b0;
                $display("FAIL %s byte %0d actual=%0h expected=%0h", tag, i, rd_data, ref_mem[i]);
            end
        end
        n_chk++;
        if (!ok) n_fail++;
    endtask

    task automatic unlock(int w1, int w2);
        strobe(1'b1, 1'b0, 16'h5555, 8'hAA, w1);
        strobe(1'b1, 1'b0, 16'h2AAA, 8'h10, w2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        check_mode("R1");
        // R4: direct erase sets a known array
        strobe(1'b1, 1'b1, 16'h0400, 8'h00, 1);
        check_mode("R4");
        check_array("R4");
        // R8: locked after erase
        strobe(1'b1, 1'b0, 16'h0003, 8'h00, 3);
        check_mode("R8");
        check_array("R8");
        do_reset();
        check_mode("R1");
        check_array("R2");
        // R3: program one byte
        strobe(1'b1, 1'b0, 16'h0003, 8'hA5, 2);
        check_mode("R3");
        check_array("R3");
        strobe(1'b1, 1'b1, 16'h0400, 8'h00, 2);
        check_mode("R8");
        check_array("R8");
        do_reset();
        // R9: no programming flag, and ale held low
        strobe(1'b0, 1'b1, 16'h0007, 8'h00, 3);
        check_mode("R9");
        @(negedge clk);
        hv_prog = 1'b1; addr = 16'h0007; din = 8'h00;
        repeat (12) @(negedge clk);
        hv_prog = 1'b0;
        check_mode("R9");
        check_array("R9");
        // R10: A9 flag without the full pattern still programs
        strobe(1'b1, 1'b1, 16'h0C07, 8'h0F, 2);
        check_mode("R10");
        check_array("R10");
        do_reset();
        // R5: unlock at window edges
        unlock(C1_MIN, C2_MAX);
        check_mode("R5");
        check_array("R5");
        do_reset();
        strobe(1'b1, 1'b0, 16'h0009, 8'h00, 1);
        do_reset();
        unlock(C1_MAX, C2_MIN);
        check_mode("R5");
        check_array("R5");
        do_reset();
        strobe(1'b1, 1'b0, 16'h000B, 8'h00, 1);
        do_reset();
        // R6: second width too long aborts
        unlock(C1_MIN, C2_MAX + 1);
        check_mode("R6");
        check_array("R6");
        // R6: first width too short, second then programs
        unlock(C1_MIN - 1, C2_MIN);
        check_mode("R6");
        check_array("R6");
        do_reset();
        strobe(1'b1, 1'b0, 16'h0005, 8'h00, 1);
        do_reset();
        // R7: wrong data at step two, then good sequence
        strobe(1'b1, 1'b0, 16'h5555, 8'hAA, C1_MIN);
        strobe(1'b1, 1'b0, 16'h2AAA, 8'h11, C2_MIN);
        check_mode("R7");
        check_array("R7");
        unlock(C1_MAX, C2_MAX);
        check_mode("R7");
        check_array("R7");
        do_reset();
        strobe(1'b1, 1'b0, 16'h0001, 8'h00, 1);
        do_reset();
        // R10: direct erase wins while armed
        strobe(1'b1, 1'b0, 16'h5555, 8'hAA, C1_MIN);
        strobe(1'b1, 1'b1, 16'h04F1, 8'h00, C2_MIN);
        check_mode("R10");
        check_array("R10");
        // random rounds
        for (int r = 0; r < 30; r++) begin
            int k = $urandom_range(5);
            logic [15:0] ra = 16'($urandom_range(16'h00FF));
            logic [7:0]  rd = 8'($urandom);
            string tag;
            do_reset();
            unique case (k)
                0: begin tag = "R3"; strobe(1'b1, 1'b0, ra, rd, $urandom_range(1, 30)); end
                1: begin tag = "R4"; strobe(1'b1, 1'b1, 16'h0400 | (ra & 16'h00FF), rd, $urandom_range(1, 30)); end
                2: begin tag = "R5"; unlock($urandom_range(C1_MIN, C1_MAX), $urandom_range(C2_MIN, C2_MAX)); end
                3: begin tag = "R6"; strobe(1'b1, 1'b0, 16'h5555, 8'hAA, C1_MIN);
                          strobe(1'b1, 1'b0, 16'h2AAA, 8'h10, $urandom_range(1, C2_MIN - 1)); end
                4: begin tag = "R7"; strobe(1'b1, 1'b0, 16'h5555, 8'hAA, C1_MAX);
                          strobe(1'b1, 1'b0, ra, 8'h10, C2_MIN); end
                default: begin tag = "R9"; strobe(1'b0, 1'($urandom), ra, rd, $urandom_range(1, 30)); end
            endcase
            check_mode(tag);
            if (ref_mode != 2'b00) begin
                strobe(1'b1, 1'b0, ra ^ 16'h0011, 8'h00, 2);
                check_mode("R8");
            end
            check_array(tag);
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule